// File: doc/BRIEF.md
# Next-PC and Processor Status Controller

This block is the sequential control core of a small 64-bit CPU. It holds the program counter and the stack pointer, and it holds the processor status as an explicit state machine. On every cycle with a step strobe it takes the decoded instruction class, the instruction length, the condition outcome, the absolute destination, the word read back from memory and the value to push. From these it computes the next PC and the new stack pointer. It drives the single memory port for push, pop, call and return, and it commits the step unless the instruction faults.

The status machine has four named states, which are also the status codes on the port. RUN_OK (1) is the only state that advances. STOP_HALT (2) is entered by the transition *halt* when a halt instruction is stepped. STOP_ADDR (3) is entered by the transition *fault* when the memory-error input accompanies a step. STOP_ILLEGAL (4) is entered by the transition *reject* when an unknown class is stepped. Every other stepped instruction takes the transition *advance* and stays in RUN_OK. The three stop states have no exit except reset. Jumps and calls load the full absolute target. They never add an offset.

Top module: `pnc_top`

## Requirements
- R1: After reset, the PC is 0, the stack pointer is the parameter SP_INIT, the status is RUN_OK (code 1), and neither memory strobe is active.
- R2: A stepped class 0x0 (halt) sets the status to STOP_HALT (code 2) and leaves the PC pointing at the halt instruction, with the stack pointer unchanged.
- R3: A stepped class above 0xB sets the status to STOP_ILLEGAL (code 4), leaves PC and stack pointer unchanged, and drives no memory strobe.
- R4: A step with the memory-error input high sets the status to STOP_ADDR (code 3) and commits no PC or stack pointer change. This takes priority over halt and illegal classes. The memory strobes still show the access that was attempted.
- R5: While the status is not RUN_OK, steps change nothing (PC, stack pointer, status) and both memory strobes stay low.
- R6: Classes 0x1 (nop), 0x2 (conditional move), 0x3 (immediate load), 0x4 (store), 0x5 (load) and 0x6 (ALU op) set the next PC to PC plus the instruction length and leave the stack pointer unchanged.
- R7: Class 0x7 (jump) loads the PC with the absolute destination when the condition input is 1. Otherwise it advances the PC by exactly 9, independent of the length input.
- R8: Class 0x8 (call) writes PC plus length to address SP-8, then sets SP to SP-8 and PC to the destination.
- R9: Class 0xA (push) writes the push value to address SP-8, sets SP to SP-8 and advances the PC by the length.
- R10: Classes 0xB (pop) and 0x9 (return) read at address SP and set SP to SP+8. Pop advances the PC by the length. Return loads the PC with the word read.
- R11: In a cycle without the step strobe, PC, stack pointer and status hold and no memory strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Execute the presented instruction this cycle |
| op_i | input | 4 | Instruction class (high nibble of the first byte) |
| ilen_i | input | 4 | Instruction length in bytes |
| cond_i | input | 1 | Condition outcome for jumps |
| dest_i | input | 64 | Absolute destination for jump and call |
| rdata_i | input | 64 | Word returned by the memory read |
| push_data_i | input | 64 | Register value to push |
| memerr_i | input | 1 | Fetch or data access fault for this step |
| pc_o | output | 64 | Program counter |
| sp_o | output | 64 | Stack pointer |
| status_o | output | 3 | Status code (1 ok, 2 halt, 3 address, 4 illegal) |
| mem_addr_o | output | 64 | Data memory address |
| mem_wdata_o | output | 64 | Data memory write value |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_re_o | output | 1 | Data memory read strobe |

## Verification
The hardest situations to reach are the stop states combined with unusual inputs: a fault on a stack operation, a halt arriving together with a memory error, and steps presented after the machine has stopped. The bench starts from a fresh reset for every combination of all sixteen classes, both condition values and both error values. It first jumps to a class-specific PC so that the PC values differ between cases. It then steps the class under test, and after that a further instruction and an idle cycle, so that freezing and holding are both observed.

// File: rtl/pnc_pkg.sv
package pnc_pkg;
    typedef enum logic [2:0] {
        RUN_OK       = 3'd1,
        STOP_HALT    = 3'd2,
        STOP_ADDR    = 3'd3,
        STOP_ILLEGAL = 3'd4
    } pnc_status_e;

    localparam logic [3:0] CL_HALT  = 4'h0;
    localparam logic [3:0] CL_NOP   = 4'h1;
    localparam logic [3:0] CL_CMOV  = 4'h2;
    localparam logic [3:0] CL_IMM   = 4'h3;
    localparam logic [3:0] CL_STORE = 4'h4;
    localparam logic [3:0] CL_LOAD  = 4'h5;
    localparam logic [3:0] CL_ALU   = 4'h6;
    localparam logic [3:0] CL_JUMP  = 4'h7;
    localparam logic [3:0] CL_CALL  = 4'h8;
    localparam logic [3:0] CL_RET   = 4'h9;
    localparam logic [3:0] CL_PUSH  = 4'hA;
    localparam logic [3:0] CL_POP   = 4'hB;

    function automatic logic class_known(input logic [3:0] c);
        return c <= CL_POP;
    endfunction
endpackage

// File: rtl/pnc_status_fsm.sv
module pnc_status_fsm
    import pnc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic [3:0]  op_i,
    input  logic        memerr_i,
    output pnc_status_e state_o,
    output logic        run_o,
    output logic        commit_o
);
    pnc_status_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_OK;
        else        state_q <= state_d;
    end

    // transitions: advance / halt / fault / reject; stop states are sticky
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_OK: begin
                if (step_i) begin
                    if (memerr_i)               state_d = STOP_ADDR;
                    else if (op_i == CL_HALT)   state_d = STOP_HALT;
                    else if (!class_known(op_i)) state_d = STOP_ILLEGAL;
                    else                        state_d = RUN_OK;
                end
            end
            STOP_HALT, STOP_ADDR, STOP_ILLEGAL: state_d = state_q;
            default: state_d = state_q;
        endcase
    end

    // outputs
    always_comb begin
        state_o  = state_q;
        run_o    = (state_q == RUN_OK);
        commit_o = run_o && step_i && !memerr_i && (op_i != CL_HALT) && class_known(op_i);
    end

    // R2: a clean halt step lands in STOP_HALT
    assert_halt_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_OK && step_i && !memerr_i && op_i == CL_HALT) |=> (state_q == STOP_HALT));

    // R3: unknown class lands in STOP_ILLEGAL
    assert_illegal_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_OK && step_i && !memerr_i && op_i > CL_POP) |=> (state_q == STOP_ILLEGAL));
endmodule

// File: rtl/pnc_pc_sel.sv
module pnc_pc_sel
    import pnc_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int JMP_LEN = 9
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [3:0]      op_i,
    input  logic [3:0]      ilen_i,
    input  logic            cond_i,
    input  logic [XLEN-1:0] dest_i,
    input  logic [XLEN-1:0] rdata_i,
    output logic [XLEN-1:0] pc_seq_o,
    output logic [XLEN-1:0] pc_next_o
);
    localparam logic [XLEN-1:0] JSTEP = XLEN'(JMP_LEN);

    always_comb begin
        pc_seq_o = pc_i + {{(XLEN-4){1'b0}}, ilen_i};
        unique case (op_i)
            CL_JUMP: pc_next_o = cond_i ? dest_i : (pc_i + JSTEP);
            CL_CALL: pc_next_o = dest_i;
            CL_RET:  pc_next_o = rdata_i;
            default: pc_next_o = pc_seq_o;
        endcase
    end
endmodule

// File: rtl/pnc_stack_port.sv
module pnc_stack_port
    import pnc_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int WORD_BYTES = 8
) (
    input  logic            active_i,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] pc_seq_i,
    input  logic [XLEN-1:0] push_data_i,
    output logic [XLEN-1:0] sp_next_o,
    output logic [XLEN-1:0] addr_o,
    output logic [XLEN-1:0] wdata_o,
    output logic            we_o,
    output logic            re_o
);
    localparam logic [XLEN-1:0] WSTEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] sp_dec, sp_inc;

    always_comb begin
        sp_dec    = sp_i - WSTEP;
        sp_inc    = sp_i + WSTEP;
        sp_next_o = sp_i;
        addr_o    = '0;
        wdata_o   = '0;
        we_o      = 1'b0;
        re_o      = 1'b0;
        unique case (op_i)
            CL_CALL, CL_PUSH: begin
                sp_next_o = sp_dec;
                addr_o    = sp_dec;
                wdata_o   = (op_i == CL_CALL) ? pc_seq_i : push_data_i;
                we_o      = active_i;
            end
            CL_RET, CL_POP: begin
                sp_next_o = sp_inc;
                addr_o    = sp_i;
                re_o      = active_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pnc_top.sv
module pnc_top
    import pnc_pkg::*;
#(
    parameter int              XLEN       = 64,
    parameter int              WORD_BYTES = 8,
    parameter int              JMP_LEN    = 9,
    parameter logic [63:0]     SP_INIT    = 64'h0000_0000_0000_0800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic [3:0]      op_i,
    input  logic [3:0]      ilen_i,
    input  logic            cond_i,
    input  logic [XLEN-1:0] dest_i,
    input  logic [XLEN-1:0] rdata_i,
    input  logic [XLEN-1:0] push_data_i,
    input  logic            memerr_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] sp_o,
    output logic [2:0]      status_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic            mem_we_o,
    output logic            mem_re_o
);
    pnc_status_e     state;
    logic            run, commit;
    logic [XLEN-1:0] pc_q, sp_q, pc_seq, pc_next, sp_next;

    pnc_status_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i),
        .memerr_i(memerr_i), .state_o(state), .run_o(run), .commit_o(commit)
    );

    pnc_pc_sel #(.XLEN(XLEN), .JMP_LEN(JMP_LEN)) u_pc (
        .pc_i(pc_q), .op_i(op_i), .ilen_i(ilen_i), .cond_i(cond_i),
        .dest_i(dest_i), .rdata_i(rdata_i), .pc_seq_o(pc_seq), .pc_next_o(pc_next)
    );

    pnc_stack_port #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_stk (
        .active_i(run && step_i), .op_i(op_i), .sp_i(sp_q), .pc_seq_i(pc_seq),
        .push_data_i(push_data_i), .sp_next_o(sp_next), .addr_o(mem_addr_o),
        .wdata_o(mem_wdata_o), .we_o(mem_we_o), .re_o(mem_re_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= XLEN'(SP_INIT);
        end else if (commit) begin
            pc_q <= pc_next;
            sp_q <= sp_next;
        end
    end

    assign pc_o     = pc_q;
    assign sp_o     = sp_q;
    assign status_o = state;

    // R5: stopped machine holds everything and issues no access
    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 3'd1) |=> ($stable(pc_o) && $stable(sp_o) && $stable(status_o)));
    assert_frozen_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 3'd1) |-> (!mem_we_o && !mem_re_o));

    // R4: a faulted step commits nothing and reports the address state
    assert_fault_nocommit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd1 && step_i && memerr_i) |=>
        (status_o == 3'd3 && $stable(pc_o) && $stable(sp_o)));

    // R8: call lands at the destination with one word pushed
    assert_call_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd1 && step_i && !memerr_i && op_i == CL_CALL) |=>
        (pc_o == $past(dest_i) && sp_o == $past(sp_o) - XLEN'(WORD_BYTES)));

    // R11: no step, no change
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(pc_o) && $stable(sp_o) && $stable(status_o)));
endmodule

// File: tb/pnc_top_test.sv
module pnc_top_test;
    localparam logic [63:0] SPI = 64'h0000_0000_0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [3:0]  op_i = '0, ilen_i = '0;
    logic        cond_i = 1'b0, memerr_i = 1'b0;
    logic [63:0] dest_i = '0, rdata_i = '0, push_data_i = '0;
    logic [63:0] pc_o, sp_o, mem_addr_o, mem_wdata_o;
    logic [2:0]  status_o;
    logic        mem_we_o, mem_re_o;

    int checks = 0, fails = 0;
    logic [63:0] m_pc, m_sp;
    logic [2:0]  m_st;

    pnc_top #(.SP_INIT(SPI)) uut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i), .ilen_i(ilen_i),
        .cond_i(cond_i), .dest_i(dest_i), .rdata_i(rdata_i), .push_data_i(push_data_i),
        .memerr_i(memerr_i), .pc_o(pc_o), .sp_o(sp_o), .status_o(status_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic st, input logic [3:0] op, input logic er, input logic [2:0] s);
        if (!st) return "R11";
        if (s != 3'd1) return "R5";
        if (er) return "R4";
        if (op == 4'h0) return "R2";
        if (op > 4'hB) return "R3";
        if (op == 4'h7) return "R7";
        if (op == 4'h8) return "R8";
        if (op == 4'hA) return "R9";
        if (op == 4'h9 || op == 4'hB) return "R10";
        return "R6";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_pc = '0; m_sp = SPI; m_st = 3'd1;
        chk("R1", "pc", pc_o, 64'd0);
        chk("R1", "sp", sp_o, SPI);
        chk("R1", "status", {61'd0, status_o}, 64'd1);
        chk("R1", "strobes", {62'd0, mem_we_o, mem_re_o}, 64'd0);
    endtask

    // caller is at a negative edge
    task automatic do_step(input logic st, input logic [3:0] op, input logic cnd,
                           input logic er, input logic [63:0] dst);
        logic [3:0]  il;
        logic [63:0] rd, pd, e_addr, e_wd;
        logic        act, e_we, e_re;
        string       tg;
        il  = 4'((op % 7) + 2);
        rd  = 64'hA5A5_0000_0000_0000 | {56'd0, op, 4'h0};
        pd  = 64'h0000_0000_DEAD_0000 + {60'd0, op};
        tg  = tag_of(st, op, er, m_st);
        step_i = st; op_i = op; ilen_i = il; cond_i = cnd; memerr_i = er;
        dest_i = dst; rdata_i = rd; push_data_i = pd;
        act  = st && (m_st == 3'd1);
        e_we = act && (op == 4'h8 || op == 4'hA);
        e_re = act && (op == 4'h9 || op == 4'hB);
        e_addr = e_we ? m_sp - 64'd8 : m_sp;
        e_wd = (op == 4'h8) ? m_pc + {60'd0, il} : pd;
        #1;
        chk(tg, "mem_we", {63'd0, mem_we_o}, {63'd0, e_we});
        chk(tg, "mem_re", {63'd0, mem_re_o}, {63'd0, e_re});
        if (e_we || e_re) chk(tg, "mem_addr", mem_addr_o, e_addr);
        if (e_we) chk(tg, "mem_wdata", mem_wdata_o, e_wd);
        if (act) begin
            if (er) m_st = 3'd3;
            else if (op == 4'h0) m_st = 3'd2;
            else if (op > 4'hB) m_st = 3'd4;
            else begin
                case (op)
                    4'h7: m_pc = cnd ? dst : m_pc + 64'd9;
                    4'h8: begin m_pc = dst; m_sp = m_sp - 64'd8; end
                    4'h9: begin m_pc = rd;  m_sp = m_sp + 64'd8; end
                    4'hA: begin m_pc = m_pc + {60'd0, il}; m_sp = m_sp - 64'd8; end
                    4'hB: begin m_pc = m_pc + {60'd0, il}; m_sp = m_sp + 64'd8; end
                    default: m_pc = m_pc + {60'd0, il};
                endcase
            end
        end
        @(negedge clk);
        step_i = 1'b0;
        chk(tg, "pc", pc_o, m_pc);
        chk(tg, "sp", sp_o, m_sp);
        chk(tg, "status", {61'd0, status_o}, {61'd0, m_st});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int e = 0; e < 2; e++) begin
                    do_reset();
                    // R7: taken jump to a class-specific base PC
                    do_step(1'b1, 4'h7, 1'b1, 1'b0, 64'h1000 + 64'(op) * 64'h40);
                    do_step(1'b1, 4'(op), c[0], e[0], 64'h2000 + 64'(op) * 64'h8);
                    // follow-up nop: advances if running, frozen (R5) if stopped
                    do_step(1'b1, 4'h1, 1'b0, 1'b0, 64'h0);
                    // R11: idle cycle with a call presented
                    do_step(1'b0, 4'h8, 1'b1, 1'b0, 64'h3000);
                end
            end
        end
        // R10 / R8 pairing: call then return restores a read-back PC
        do_reset();
        do_step(1'b1, 4'h8, 1'b0, 1'b0, 64'h0000_0000_0000_0400);
        do_step(1'b1, 4'h9, 1'b0, 1'b0, 64'h0);
        do_step(1'b1, 4'hA, 1'b0, 1'b0, 64'h0);
        do_step(1'b1, 4'hB, 1'b0, 1'b0, 64'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule